// File: doc/BRIEF.md
# Shared Load-Linked / Store-Conditional Reservation Table

This block keeps atomic reservations at a shared memory controller. A processor that performs a load-linked access is given a signature key, and the controller passes that key back with the read data. When the same processor later performs a store-conditional, it presents the key again. The store succeeds only if the reservation still exists and the key matches. A plain store to the address destroys the reservation. The controller issues a plain-store request for every successful compare-and-swap as well. Requests come from the controller's read, write and compare-and-swap sequencers while they hold the directory. At most one request arrives per cycle.

The table has a fixed, parameterised number of slots. This number is independent of the processor count, so the structure does not grow with the system. A reservation is identified by a key built from the slot number and a per-slot generation count, not by a per-processor bit. A global counter advances on every load-linked request. A reservation lapses once this counter has moved more than a set lifespan past the reservation's last registration. When the table is full, a new reservation displaces the oldest one.

Results are combinational in the cycle of the request. The table state changes at the following clock edge.

Top module: `llsc_sig_table`

## Requirements
- R1: After reset, no reservation exists. A store-conditional fails. With `op_i` = 2'b00 (idle), both `ll_key_o` and `sc_ok_o` are 0.
- R2: The operation encoding is 2'b01 load-linked, 2'b10 store-conditional, 2'b11 plain store. For a load-linked request, `ll_key_o` returns, in the same cycle, the key {generation, slot index}. The slot index occupies the low log2(SLOTS) bits. For any other operation, `ll_key_o` is 0.
- R3: A store-conditional raises `sc_ok_o` in the same cycle only if a reservation exists for `addr_i` in the slot named by the key's index field, and that slot's generation equals the key's generation field.
- R4: A successful store-conditional removes its reservation, so a repeat with the same key fails.
- R5: A plain store removes the reservation on its own address. Reservations on other addresses stay valid.
- R6: A load-linked request to an address that already holds a reservation returns the existing key unchanged and resets that reservation's age to zero.
- R7: A new reservation takes the lowest-numbered free slot. Its generation is one more than the slot's previous generation (0 after reset), so a reused slot yields a different key.
- R8: When no slot is free, the new reservation replaces the one with the largest age. Ties go to the lower index.
- R9: A reservation stays valid for LIFE further load-linked requests after it is registered or refreshed. It is gone once the next load-linked request after that has been accepted.
- R10: A store-conditional that fails leaves every reservation unchanged. A stale generation, another slot's index and a different address are all failure cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation: 00 idle, 01 load-linked, 10 store-conditional, 11 plain store |
| addr_i | input | ADDR_W | Address of the operation |
| key_i | input | GEN_W+log2(SLOTS) | Key presented by a store-conditional |
| ll_key_o | output | GEN_W+log2(SLOTS) | Key returned for a load-linked request |
| sc_ok_o | output | 1 | Store-conditional success |

## Verification
Store-conditionals are tried with the current key, with a key from an earlier generation of the same slot, and with a correct key on the wrong address. This separates the key check from the address check. Plain stores are applied both to a reserved address and to an unrelated address, which shows that invalidation is targeted. The table is filled with and without an intervening re-registration of the first entry. This distinguishes age-based eviction from eviction by slot position. Runs of exactly LIFE and of LIFE+1 later load-linked requests fix the expiry boundary to the cycle.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_LL    = 2'b01,
      OP_SC    = 2'b10,
      OP_STORE = 2'b11
   } llsc_op_e;
endpackage

// File: rtl/llsc_slot.sv
`timescale 1ns/1ps
// One reservation slot: address, generation and registration stamp.
module llsc_slot #(
   parameter int ADDR_W = 32,
   parameter int GEN_W  = 8,
   parameter int CNT_W  = 14,
   parameter int LIFE   = 8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              alloc_i,
   input  logic              refresh_i,
   input  logic              kill_i,
   input  logic              sweep_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [GEN_W-1:0]  gen_o,
   output logic [CNT_W-1:0]  age_o
);
   logic [CNT_W-1:0] stamp_q;
   logic             lapse;

   assign age_o = cnt_i - stamp_q;
   // the next LL would push the age past LIFE
   assign lapse = valid_o && (age_o >= CNT_W'(LIFE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
         gen_o   <= '0;
         stamp_q <= '0;
      end else if (alloc_i) begin
         valid_o <= 1'b1;
         addr_o  <= addr_i;
         gen_o   <= gen_o + 1'b1;
         stamp_q <= cnt_i + 1'b1;
      end else if (refresh_i) begin
         stamp_q <= cnt_i + 1'b1;
      end else if (kill_i) begin
         valid_o <= 1'b0;
      end else if (sweep_i && lapse) begin
         valid_o <= 1'b0;
      end
   end

   a_r9_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (age_o <= CNT_W'(LIFE)));

   a_r7_alloc_gen: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |=> (valid_o && gen_o == $past(gen_o) + 1'b1));

   a_r6_refresh_young: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_i |=> (valid_o && age_o == '0));
endmodule

// File: rtl/llsc_victim.sv
`timescale 1ns/1ps
// Chooses the slot for a new reservation: lowest free slot, else the oldest.
module llsc_victim #(
   parameter int SLOTS = 32,
   parameter int CNT_W = 14,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0]            valid_i,
   input  logic [SLOTS-1:0][CNT_W-1:0] age_i,
   output logic [IDX_W-1:0]            pick_o
);
   logic             any_free;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] old_idx;
   logic [CNT_W-1:0] old_age;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      old_idx = '0;
      old_age = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (valid_i[i] && (i == 0 || age_i[i] > old_age)) begin
            old_idx = IDX_W'(i);
            old_age = age_i[i];
         end
      end
   end

   assign pick_o = any_free ? free_idx : old_idx;
endmodule

// File: rtl/llsc_sig_table.sv
`timescale 1ns/1ps
module llsc_sig_table
   import llsc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLOTS  = 32,
   parameter int NPROC  = 4096,
   parameter int LIFE   = 8000,
   parameter int GEN_W  = 8,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int KEY_W = GEN_W + IDX_W,
   localparam int CNT_W = $clog2(LIFE + 2) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [KEY_W-1:0]  key_i,
   output logic [KEY_W-1:0]  ll_key_o,
   output logic              sc_ok_o
);
   if (SLOTS < 2)  $error("llsc_sig_table: SLOTS must be at least 2");
   if (LIFE < 1)   $error("llsc_sig_table: LIFE must be at least 1");
   if (GEN_W < 1)  $error("llsc_sig_table: GEN_W must be at least 1");
   if (NPROC < 1)  $error("llsc_sig_table: NPROC must be at least 1");
   if (ADDR_W < 1) $error("llsc_sig_table: ADDR_W must be at least 1");

   llsc_op_e op;
   logic     is_ll, is_sc, is_st;
   assign op    = llsc_op_e'(op_i);
   assign is_ll = (op == OP_LL);
   assign is_sc = (op == OP_SC);
   assign is_st = (op == OP_STORE);

   logic [CNT_W-1:0]             ll_cnt_q;
   logic [SLOTS-1:0]             s_vld;
   logic [SLOTS-1:0][ADDR_W-1:0] s_addr;
   logic [SLOTS-1:0][GEN_W-1:0]  s_gen;
   logic [SLOTS-1:0][CNT_W-1:0]  s_age;
   logic [SLOTS-1:0]             hit_vec, sc_vec;
   logic [SLOTS-1:0]             alloc_vec, refr_vec, kill_vec;
   logic                         hit_any;
   logic [IDX_W-1:0]             hit_idx, victim, target;
   logic [IDX_W-1:0]             key_idx;
   logic [GEN_W-1:0]             key_gen, out_gen;

   assign key_idx = key_i[IDX_W-1:0];
   assign key_gen = key_i[KEY_W-1:IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n)     ll_cnt_q <= '0;
      else if (is_ll) ll_cnt_q <= ll_cnt_q + 1'b1;
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign hit_vec[g]   = s_vld[g] && (s_addr[g] == addr_i);
      assign sc_vec[g]    = is_sc && hit_vec[g] && (key_idx == IDX_W'(g))
                            && (s_gen[g] == key_gen);
      assign alloc_vec[g] = is_ll && !hit_any && (victim == IDX_W'(g));
      assign refr_vec[g]  = is_ll && hit_any && (hit_idx == IDX_W'(g));
      assign kill_vec[g]  = sc_vec[g] || (is_st && hit_vec[g]);

      llsc_slot #(
         .ADDR_W (ADDR_W),
         .GEN_W  (GEN_W),
         .CNT_W  (CNT_W),
         .LIFE   (LIFE)
      ) slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_i     (ll_cnt_q),
         .alloc_i   (alloc_vec[g]),
         .refresh_i (refr_vec[g]),
         .kill_i    (kill_vec[g]),
         .sweep_i   (is_ll),
         .addr_i    (addr_i),
         .valid_o   (s_vld[g]),
         .addr_o    (s_addr[g]),
         .gen_o     (s_gen[g]),
         .age_o     (s_age[g])
      );
   end

   always_comb begin
      hit_any = 1'b0;
      hit_idx = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (hit_vec[i]) begin
            hit_any = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   llsc_victim #(
      .SLOTS (SLOTS),
      .CNT_W (CNT_W)
   ) victim_i (
      .valid_i (s_vld),
      .age_i   (s_age),
      .pick_o  (victim)
   );

   assign target = hit_any ? hit_idx : victim;

   always_comb begin
      out_gen = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (target == IDX_W'(i)) out_gen = hit_any ? s_gen[i] : s_gen[i] + 1'b1;
      end
   end

   assign ll_key_o = is_ll ? {out_gen, target} : '0;
   assign sc_ok_o  = |sc_vec;

   // one reservation per address at most
   a_r5_unique_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r3_sc_only_on_sc: assert property (@(posedge clk) disable iff (!rst_n)
      sc_ok_o |-> (op_i == 2'b10));

   a_r4_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      sc_ok_o |=> !s_vld[$past(key_idx)]);

   a_r2_key_only_on_ll: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i != 2'b01) |-> (ll_key_o == '0));

   a_r6_ll_leaves_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'b01) |=> (s_vld[$past(target)] && s_addr[$past(target)] == $past(addr_i)));
endmodule

// File: tb/llsc_sig_table_tb.sv
`timescale 1ns/1ps
module llsc_sig_table_tb_top;
   localparam int AW = 16;
   localparam int NS = 4;
   localparam int LF = 4;
   localparam int GW = 4;
   localparam int KW = GW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op_i = 2'b00;
   logic [AW-1:0] addr_i = '0;
   logic [KW-1:0] key_i = '0;
   logic [KW-1:0] ll_key_o;
   logic          sc_ok_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [KW-1:0] got_key;
   logic          got_ok;

   localparam logic [1:0] LL = 2'b01, SC = 2'b10, ST = 2'b11;
   localparam logic [AW-1:0] A = 16'h0100, B = 16'h0200, C = 16'h0300,
                             D = 16'h0400, E = 16'h0500;

   always #2 clk = ~clk;

   llsc_sig_table #(
      .ADDR_W (AW), .SLOTS (NS), .NPROC (16), .LIFE (LF), .GEN_W (GW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .op_i (op_i), .addr_i (addr_i),
      .key_i (key_i), .ll_key_o (ll_key_o), .sc_ok_o (sc_ok_o)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_op(logic [1:0] k, logic [AW-1:0] a, logic [KW-1:0] key);
      @(negedge clk);
      op_i = k; addr_i = a; key_i = key;
      #1;
      got_key = ll_key_o;
      got_ok  = sc_ok_o;
   endtask

   task automatic do_reset();
      @(negedge clk);
      op_i = 2'b00; rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // key {gen, idx}
   function automatic logic [KW-1:0] mk(int gen, int idx);
      return KW'((gen << 2) | idx);
   endfunction

   task automatic t_reset();
      do_reset();
      do_op(2'b00, A, '0);
      chk("R1 idle key", got_key, 0);
      chk("R1 idle ok", got_ok, 0);
      do_op(SC, A, mk(1, 0));
      chk("R1 sc after reset", got_ok, 0);
   endtask

   task automatic t_basic();
      do_reset();
      do_op(LL, A, '0);
      chk("R2 first key", got_key, mk(1, 0));
      chk("R2 no sc_ok on ll", got_ok, 0);
      do_op(SC, A, mk(1, 0));
      chk("R3 sc success", got_ok, 1);
      chk("R2 key zero on sc", got_key, 0);
      do_op(SC, A, mk(1, 0));
      chk("R4 repeat sc fails", got_ok, 0);
      do_op(LL, B, '0);
      chk("R7 reused slot new gen", got_key, mk(2, 0));
      do_op(SC, B, mk(1, 0));
      chk("R10 stale gen fails", got_ok, 0);
      do_op(SC, C, mk(2, 0));
      chk("R10 wrong address fails", got_ok, 0);
      do_op(SC, B, mk(2, 1));
      chk("R10 wrong slot index fails", got_ok, 0);
      do_op(SC, B, mk(2, 0));
      chk("R10 reservation intact after failures", got_ok, 1);
   endtask

   task automatic t_store();
      do_reset();
      do_op(LL, A, '0);
      chk("R7 slot0", got_key, mk(1, 0));
      do_op(LL, B, '0);
      chk("R7 lowest free slot1", got_key, mk(1, 1));
      do_op(ST, C, '0);
      chk("R2 key zero on store", got_key, 0);
      do_op(ST, B, '0);
      do_op(SC, B, mk(1, 1));
      chk("R5 store kills reservation", got_ok, 0);
      do_op(SC, A, mk(1, 0));
      chk("R5 other address untouched", got_ok, 1);
   endtask

   task automatic t_evict(bit refresh);
      do_reset();
      do_op(LL, A, '0);
      do_op(LL, B, '0);
      do_op(LL, C, '0);
      if (refresh) begin
         do_op(LL, A, '0);
         chk("R6 hit returns same key", got_key, mk(1, 0));
      end
      do_op(LL, D, '0);
      chk("R7 fourth slot", got_key, mk(1, 3));
      do_op(LL, E, '0);
      if (refresh) begin
         chk("R8 oldest slot1 evicted", got_key, mk(2, 1));
         do_op(SC, B, mk(1, 1));
         chk("R8 evicted sc fails", got_ok, 0);
         do_op(SC, A, mk(1, 0));
         chk("R6 refreshed entry kept", got_ok, 1);
      end else begin
         chk("R8 oldest slot0 evicted", got_key, mk(2, 0));
         do_op(SC, A, mk(1, 0));
         chk("R8 evicted sc fails", got_ok, 0);
         do_op(SC, B, mk(1, 1));
         chk("R8 younger entry kept", got_ok, 1);
      end
   endtask

   task automatic t_life(int extra);
      do_reset();
      do_op(LL, A, '0);
      for (int i = 0; i < extra; i++) begin
         do_op(LL, B, '0);
         chk("R9 hit key stable", got_key, mk(1, 1));
      end
      do_op(SC, A, mk(1, 0));
      chk(extra <= LF ? "R9 alive at lifespan" : "R9 expired past lifespan",
          got_ok, extra <= LF ? 1 : 0);
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_store();
      t_evict(1'b1);
      t_evict(1'b0);
      t_life(LF);
      t_life(LF + 1);
      @(negedge clk);
      op_i = 2'b00;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule